// File: doc/BRIEF.md
# Dual Alarm Match and Interrupt Unit

This unit holds two alarm banks and checks each against the running time of day. Each bank has four fields: seconds, minutes, hours and day of week. The time counter presents the current BCD fields together with a one-cycle second strobe. On each strobe, every bank compares its fields with the current time. Any field whose top bit is set is left out of the comparison. When a bank matches, that bank's flag is set. The flag stays set until software acknowledges it.

The register bus gives software access to both banks, a small control register and a status register. Control bits enable the interrupt for each alarm and choose how alarm 1 is routed. Alarm 1 can share the first active-low interrupt pin with alarm 0, or it can drive its own active-low pin. A flag is acknowledged in either of two ways: by any read or write that touches the alarm's bank, or by writing zero to its status bit. Turning off an enable silences that alarm's pin but leaves its flag set.

Top module: `alarm_pair_irq`

## Requirements
- R1: After reset, every alarm field, the control register and both flags are zero, and both interrupt pins are high.
- R2: The register map is as follows, and each register reads back combinationally on `bus_rdata`:
  - Bank 0 occupies addresses 0x07..0x0A and bank 1 occupies 0x0B..0x0E. Within a bank the field order is seconds, minutes, hours, day of week.
  - Control is at 0x10-1 (0x0F) and status is at 0x10.
  - Any other address reads zero.
  - A write happens when `bus_sel` and `bus_we` are both high at a clock edge.
- R3: A flag is set only at an edge where `sec_tick` is high and every unmasked field of its bank equals the matching current-time field. The flag is visible from the next cycle.
- R4: A field with bit 7 set (0x80) is excluded from the comparison. A bank with all four fields masked matches on every strobe.
- R5: Status bit 0 is the flag of alarm 0 and status bit 1 is the flag of alarm 1. Writing 0 to a status bit clears that flag. Writing 1 leaves it unchanged.
- R6: Any access, read or write, to an address in a bank clears that bank's flag and leaves the other bank's flag unchanged.
- R7: When a match and a clear of the same flag occur at the same edge, the flag ends up clear.
- R8: Control bit 0 enables the alarm 0 interrupt and control bit 1 enables the alarm 1 interrupt. An interrupt is active only while both its flag and its enable are set. Clearing an enable releases the pin and leaves the flag set.
- R9: Control bit 2 selects the routing of alarm 1:
  - When bit 2 is 0, both alarms pull `irq0_n` low and `irq1_n` stays high.
  - When bit 2 is 1, alarm 1 drives only `irq1_n`.
- R10: A set flag holds through later strobes, matching or not, until one of the clears in R5 or R6 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe, current time is valid |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, encoded as the time counter keeps them |
| cur_dow | input | 8 | Current day of week |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq0_n | output | 1 | Active-low interrupt, alarm 0 and shared alarm 1 |
| irq1_n | output | 1 | Active-low interrupt, alarm 1 when routed apart |

## Verification
The assertions check, on every cycle, the rules that depend only on local state:
- a flag can rise only after a strobe;
- a bank access or a zero status write leaves the flag clear;
- a flag holds while the bus is idle;
- the second pin stays high in shared mode;
- no pin is active while both enables are off.

Other behaviour shows up only in the bench's scenarios, which compare against a model of the requirements:
- whether a flag is set depends on the field values and the masks, so only stimulus can reveal it;
- clear-beats-match in the same edge;
- the combined effect of enables and routing on both pins.

// File: rtl/alarm_pair_irq.sv
module alarm_pair_irq #(
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter int ALM_BASE  = 7,
  parameter int CTRL_ADDR = 15,
  parameter int STAT_ADDR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_dow,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq0_n,
  output logic          irq1_n
);
  localparam int FIELDS = 4;
  localparam int NALM   = 2;

  logic [DW-1:0] alm_q [NALM][FIELDS];
  logic [DW-1:0] cur_f [FIELDS];
  logic [2:0]    ctrl_q;
  logic [NALM-1:0] flag_q, hit, bank_acc, clr, live;

  assign cur_f[0] = cur_sec;
  assign cur_f[1] = cur_min;
  assign cur_f[2] = cur_hour;
  assign cur_f[3] = cur_dow;

  wire wr_en   = bus_sel & bus_we;
  wire stat_wr = wr_en & (bus_addr == AW'(STAT_ADDR));
  wire ctrl_wr = wr_en & (bus_addr == AW'(CTRL_ADDR));

  for (genvar a = 0; a < NALM; a++) begin : g_alm
    logic [FIELDS-1:0] fld_ok;
    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
      assign fld_ok[f] = alm_q[a][f][DW-1] | (alm_q[a][f] == cur_f[f]);
    end
    assign hit[a]      = sec_tick & (&fld_ok);
    assign bank_acc[a] = bus_sel & (bus_addr >= AW'(ALM_BASE + a*FIELDS))
                                 & (bus_addr <  AW'(ALM_BASE + (a+1)*FIELDS));
  end

  assign clr = bank_acc | (stat_wr ? ~bus_wdata[NALM-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ctrl_q <= '0;
      for (int a = 0; a < NALM; a++)
        for (int f = 0; f < FIELDS; f++)
          alm_q[a][f] <= '0;
    end else begin
      flag_q <= (flag_q | hit) & ~clr;
      if (ctrl_wr) ctrl_q <= bus_wdata[2:0];
      for (int a = 0; a < NALM; a++)
        for (int f = 0; f < FIELDS; f++)
          if (wr_en && bus_addr == AW'(ALM_BASE + a*FIELDS + f))
            alm_q[a][f] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int a = 0; a < NALM; a++)
      for (int f = 0; f < FIELDS; f++)
        if (bus_addr == AW'(ALM_BASE + a*FIELDS + f)) bus_rdata = alm_q[a][f];
    if (bus_addr == AW'(CTRL_ADDR)) bus_rdata = DW'(ctrl_q);
    if (bus_addr == AW'(STAT_ADDR)) bus_rdata = DW'(flag_q);
  end

  assign live   = flag_q & ctrl_q[1:0];
  assign irq0_n = ~(live[0] | (live[1] & ~ctrl_q[2]));
  assign irq1_n = ~(live[1] & ctrl_q[2]);
endmodule

module alarm_pair_irq_chk #(
  parameter int AW        = 8,
  parameter int ALM_BASE  = 7,
  parameter int STAT_ADDR = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_tick,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    wdata_lo,
  input logic          irq0_n,
  input logic          irq1_n,
  input logic [1:0]    flag_q,
  input logic [2:0]    ctrl_q
);
  wire b0 = bus_sel && bus_addr >= AW'(ALM_BASE)   && bus_addr < AW'(ALM_BASE+4);
  wire b1 = bus_sel && bus_addr >= AW'(ALM_BASE+4) && bus_addr < AW'(ALM_BASE+8);
  wire sw = bus_sel && bus_we && bus_addr == AW'(STAT_ADDR);

  p_rise_on_tick0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(sec_tick));
  p_rise_on_tick1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(sec_tick));
  p_bank0_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b0 |=> !flag_q[0]);
  p_bank1_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b1 |=> !flag_q[1]);
  p_stat_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw && !wdata_lo[0]) |=> !flag_q[0]);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !bus_sel) |=> flag_q[1]);
  p_shared_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[2] |-> irq1_n);
  p_enables_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1:0] == 2'b00) |-> (irq0_n && irq1_n));
endmodule

bind alarm_pair_irq alarm_pair_irq_chk #(.AW(AW), .ALM_BASE(ALM_BASE), .STAT_ADDR(STAT_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .wdata_lo(bus_wdata[1:0]), .irq0_n(irq0_n), .irq1_n(irq1_n),
  .flag_q(flag_q), .ctrl_q(ctrl_q));

// File: tb/alarm_pair_irq_tb.sv
module alarm_pair_irq_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic sec_tick = 0, bus_sel = 0, bus_we = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_dow = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  wire  [7:0] bus_rdata;
  wire irq0_n, irq1_n;

  int checks = 0, errors = 0;
  logic [7:0] m_alm [2][4];
  logic [2:0] m_ctrl = 0;
  logic [1:0] m_flag = 0;
  logic [7:0] rd;

  alarm_pair_irq dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq0_n(irq0_n), .irq1_n(irq1_n));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_match(int a);
    logic [7:0] c [4];
    bit ok = 1;
    c[0] = cur_sec; c[1] = cur_min; c[2] = cur_hour; c[3] = cur_dow;
    for (int f = 0; f < 4; f++)
      if (!m_alm[a][f][7] && m_alm[a][f] != c[f]) ok = 0;
    return ok;
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] ad);
    if (ad >= 7 && ad <= 14) return m_alm[(ad-7)/4][(ad-7)%4];
    if (ad == 15) return {5'b0, m_ctrl};
    if (ad == 16) return {6'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic check_pins();
    logic e0, e1;
    e0 = !((m_flag[0] & m_ctrl[0]) | (m_flag[1] & m_ctrl[1] & !m_ctrl[2]));
    e1 = !(m_flag[1] & m_ctrl[1] & m_ctrl[2]);
    chk(irq0_n === e0, "R8 R9 irq0_n", irq0_n, e0);
    chk(irq1_n === e1, "R8 R9 irq1_n", irq1_n, e1);
  endtask

  task automatic step(bit tk, bit sel, bit we, logic [7:0] ad, logic [7:0] wd, output logic [7:0] r);
    logic [1:0] set, clr;
    @(negedge clk);
    sec_tick = tk; bus_sel = sel; bus_we = we; bus_addr = ad; bus_wdata = wd;
    #1 r = bus_rdata;
    set = tk ? {m_match(1), m_match(0)} : 2'b00;
    clr = 2'b00;
    if (sel && ad >= 7 && ad <= 10) clr[0] = 1;
    if (sel && ad >= 11 && ad <= 14) clr[1] = 1;
    if (sel && we && ad == 16) clr = clr | ~wd[1:0];
    @(posedge clk); #1;
    sec_tick = 0; bus_sel = 0; bus_we = 0;
    m_flag = (m_flag | set) & ~clr;
    if (sel && we) begin
      if (ad >= 7 && ad <= 14) m_alm[(ad-7)/4][(ad-7)%4] = wd;
      if (ad == 15) m_ctrl = wd[2:0];
    end
    check_pins();
  endtask

  task automatic wr(logic [7:0] ad, logic [7:0] wd);
    step(0, 1, 1, ad, wd, rd);
  endtask

  task automatic rd_chk(logic [7:0] ad, string tag);
    logic [7:0] e;
    e = m_read(ad);
    step(0, 1, 0, ad, 0, rd);
    chk(rd === e, tag, rd, e);
  endtask

  task automatic tick(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
    cur_sec = s; cur_min = m; cur_hour = h; cur_dow = d;
    step(1, 0, 0, 0, 0, rd);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired, run did not complete (all R1..R10)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 2; a++) for (int f = 0; f < 4; f++) m_alm[a][f] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(irq0_n === 1'b1, "R1 irq0_n after reset", irq0_n, 1);
    chk(irq1_n === 1'b1, "R1 irq1_n after reset", irq1_n, 1);
    for (int ad = 7; ad <= 16; ad++) rd_chk(8'(ad), "R1 register zero after reset");

    wr(8'h07, 8'h15); wr(8'h08, 8'h30); wr(8'h09, 8'h08); wr(8'h0A, 8'h03);
    wr(8'h0B, 8'h45); wr(8'h0C, 8'h59); wr(8'h0D, 8'h23); wr(8'h0E, 8'h07);
    for (int ad = 7; ad <= 14; ad++) rd_chk(8'(ad), "R2 alarm readback");
    rd_chk(8'h05, "R2 unmapped reads zero");
    rd_chk(8'h11, "R2 unmapped reads zero");
    wr(8'h0F, 8'h03);
    rd_chk(8'h0F, "R2 control readback");

    cur_sec = 8'h15; cur_min = 8'h30; cur_hour = 8'h08; cur_dow = 8'h03;
    step(0, 0, 0, 0, 0, rd);
    rd_chk(8'h10, "R3 no set without strobe");
    tick(8'h15, 8'h30, 8'h08, 8'h03);
    rd_chk(8'h10, "R3 alarm0 match sets flag");
    chk(irq0_n === 1'b0, "R3 irq0_n active after match", irq0_n, 0);
    tick(8'h16, 8'h30, 8'h08, 8'h03);
    step(0, 0, 0, 0, 0, rd);
    rd_chk(8'h10, "R10 flag holds");
    wr(8'h10, 8'h02);
    rd_chk(8'h10, "R5 zero write clears flag0");

    wr(8'h0B, 8'h80); wr(8'h0C, 8'h80); wr(8'h0D, 8'h80); wr(8'h0E, 8'h80);
    tick(8'h42, 8'h11, 8'h19, 8'h05);
    rd_chk(8'h10, "R4 fully masked bank matches");
    wr(8'h10, 8'h01);
    rd_chk(8'h10, "R5 zero write clears flag1");
    wr(8'h0B, 8'h05);
    tick(8'h06, 8'h00, 8'h00, 8'h01);
    rd_chk(8'h10, "R4 unmasked seconds mismatch");
    tick(8'h05, 8'h27, 8'h13, 8'h02);
    rd_chk(8'h10, "R4 unmasked seconds match");

    tick(8'h15, 8'h30, 8'h08, 8'h03);
    rd_chk(8'h10, "R6 both flags set");
    rd_chk(8'h0C, "R6 bank1 read");
    rd_chk(8'h10, "R6 bank1 read cleared only flag1");
    wr(8'h0A, 8'h03);
    rd_chk(8'h10, "R6 bank0 write cleared flag0");

    cur_sec = 8'h15; cur_min = 8'h30; cur_hour = 8'h08; cur_dow = 8'h03;
    step(1, 1, 0, 8'h07, 0, rd);
    rd_chk(8'h10, "R7 clear beats match");

    tick(8'h15, 8'h30, 8'h08, 8'h03);
    wr(8'h0F, 8'h02);
    chk(irq0_n === 1'b1, "R8 disabled enable releases pin", irq0_n, 1);
    rd_chk(8'h10, "R8 flag kept after disable");

    tick(8'h05, 8'h00, 8'h00, 8'h00);
    wr(8'h0F, 8'h06);
    chk(irq1_n === 1'b0, "R9 routed alarm1 on irq1_n", irq1_n, 0);
    chk(irq0_n === 1'b1, "R9 irq0_n idle when routed", irq0_n, 1);
    wr(8'h0F, 8'h02);
    chk(irq0_n === 1'b0, "R9 shared alarm1 on irq0_n", irq0_n, 0);
    chk(irq1_n === 1'b1, "R9 irq1_n idle when shared", irq1_n, 1);

    for (int i = 0; i < 400; i++) begin
      case ($urandom % 5)
        0: wr(8'(7 + $urandom % 8), (($urandom % 3) == 0 ? 8'h80 : 8'h00) | 8'($urandom % 3));
        1: tick(8'($urandom % 3), 8'($urandom % 3), 8'($urandom % 3), 8'($urandom % 3));
        2: rd_chk(8'(7 + $urandom % 10), "R2 R6 random read");
        3: wr(8'h0F, 8'($urandom % 8));
        default: wr(8'h10, 8'($urandom % 4));
      endcase
      if (i % 8 == 0) rd_chk(8'h10, "R3 R5 random status");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule